// File: doc/BRIEF.md
# SPI Register Command Slave

This block is the serial control port of a supervisor device. A host drives 16-bit frames over a four-wire serial link in mode 0 (data sampled on the rising clock edge and changed on the falling edge, most significant bit first). Each frame holds a 2-bit command, a 5-bit register address, a parity/next bit and a data byte. The block decodes the frame and performs one of three actions: it writes a register, reads a register back, or reads and clears the sticky flag byte. Throughout every frame it returns a status word on MISO.

The register space has three parts. Five setup registers drive the block's configuration outputs. Four scratch bytes hold whatever the host last wrote to them. One mode-select register is guarded: a host must first read a challenge byte, then write back its bitwise inverse. All serial inputs are sampled in the system clock domain. A frame takes effect only when chip select is released after exactly 16 clock pulses.

Top module: `spi_cmd_slave`

## Requirements
- R1: Frame layout, MSB first: bits 15-14 command, bits 13-9 address, bit 8 parity/next, bits 7-0 data. A frame acts only if exactly 16 SCLK rising edges occur between the fall and the rise of cs_n.
- R2: While cs_n is low, MISO bits 15-8 carry fixed_status as sampled when cs_n falls. While cs_n is high, MISO is 0.
- R3: Command 01 writes the data byte. Addresses 0-4 drive cfg_misc, cfg_linio, cfg_supply, cfg_wdog and cfg_amux in that order. Addresses 5-8 are scratch bytes. All of them reset to 0.
- R4: Command 00 returns the addressed byte in MISO bits 7-0. Addresses 10-31 read as 0, and writes to them change nothing.
- R5: During command 01 and command 10 frames, MISO bits 7-0 carry ext_status.
- R6: Command 10 is reserved and changes no register and no flag.
- R7: A frame with any other edge count is discarded and sets flag bit 7 (framing error).
- R8: When cfg_misc bit 0 is 1, a write to an address other than 9 is dropped if bit 8 differs from the XOR of bits 15-9 and 7-0, and flag bit 6 (parity error) is set.
- R9: The flag byte is {framing error, parity error, evt[5:0]}. Every bit is sticky. Command 11 at any address returns it in MISO bits 7-0. The bits it reported are cleared when that frame completes.
- R10: A read of address 9 returns the current challenge byte (0x5A after reset) and arms that byte. The next challenge byte is then taken from a free-running 8-bit LFSR.
- R11: A write to address 9 sets mode_sel only if a challenge is armed, bit 8 is 1, and the data equals the inverse of the armed byte. Parity checking does not apply to it. Any write to address 9 disarms the challenge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from host |
| fixed_status | input | 8 | Status byte sent first in every frame |
| ext_status | input | 8 | Second status byte for write and reserved frames |
| evt | input | 6 | Event inputs latched into the flag byte |
| miso | output | 1 | Serial data to host |
| cfg_misc | output | 8 | Setup register 0 (bit 0 enables parity) |
| cfg_linio | output | 8 | Setup register 1 |
| cfg_supply | output | 8 | Setup register 2 |
| cfg_wdog | output | 8 | Setup register 3 |
| cfg_amux | output | 8 | Setup register 4 |
| mode_sel | output | 8 | Guarded mode register |

## Verification
The serial inputs pass through a two-stage synchronizer. As a result, a new MISO bit is ready at most four system cycles after each SCLK falling edge, and after the cs_n fall. The bench samples MISO six cycles after that edge, just before it raises SCLK. Register, mode and flag effects appear about five cycles after cs_n rises, so the bench waits twelve cycles after cs_n rises before it compares outputs or starts the next frame. An evt pulse reaches the flag byte one cycle later, well before the flag read that checks it.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int FRAME_BITS = 16;
  localparam int BYTE_BITS  = 8;
  localparam int ADDR_BITS  = 5;
  localparam int CMD_BITS   = 2;

  typedef enum logic [CMD_BITS-1:0] {
    CMD_RDBK  = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_RSVD  = 2'b10,
    CMD_FLAGS = 2'b11
  } cmd_e;

endpackage

// File: rtl/spi_frame_port.sv
module spi_frame_port
  import spi_cmd_pkg::*;
#(
  parameter int FRAME_W = FRAME_BITS,
  parameter int DATA_W  = BYTE_BITS,
  parameter int ADDR_W  = ADDR_BITS,
  parameter int SYNC    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_i,
  input  logic               cs_n_i,
  input  logic               mosi_i,
  input  logic [DATA_W-1:0]  fixed_status_i,
  input  logic [DATA_W-1:0]  low_byte_i,
  output logic               miso_o,
  output cmd_e               hdr_cmd_o,
  output logic [ADDR_W-1:0]  hdr_addr_o,
  output logic               low_load_o,
  output logic               commit_o,
  output logic               commit_ok_o,
  output logic [FRAME_W-1:0] word_o
);

  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] HDR_FALLS = CNT_W'(DATA_W - 1);
  localparam int LOW_PAD = FRAME_W - DATA_W;

  logic [SYNC:0]   sclk_sh, cs_sh;
  logic [SYNC-1:0] mosi_sh;
  logic sclk_rise, sclk_fall, cs_fall, cs_rise, cs_act, mosi_s;

  logic [FRAME_W-1:0] rx_q, rx_d, tx_q, tx_d;
  logic [CNT_W-1:0]   rc_q, rc_d, fc_q, fc_d;
  logic               load_q, load_d, commit_q, commit_d, ok_q, ok_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sh <= '0;
      cs_sh   <= '1;
      mosi_sh <= '0;
    end else begin
      sclk_sh <= {sclk_sh[SYNC-1:0], sclk_i};
      cs_sh   <= {cs_sh[SYNC-1:0], cs_n_i};
      mosi_sh <= {mosi_sh[SYNC-2:0], mosi_i};
    end
  end

  assign sclk_rise = sclk_sh[SYNC-1] & ~sclk_sh[SYNC];
  assign sclk_fall = ~sclk_sh[SYNC-1] & sclk_sh[SYNC];
  assign cs_fall   = ~cs_sh[SYNC-1] & cs_sh[SYNC];
  assign cs_rise   = cs_sh[SYNC-1] & ~cs_sh[SYNC];
  assign cs_act    = ~cs_sh[SYNC-1];
  assign mosi_s    = mosi_sh[SYNC-1];

  always_comb begin
    rx_d     = rx_q;
    tx_d     = tx_q;
    rc_d     = rc_q;
    fc_d     = fc_q;
    load_d   = 1'b0;
    commit_d = 1'b0;
    ok_d     = 1'b0;
    if (cs_fall) begin
      tx_d = {fixed_status_i, {LOW_PAD{1'b0}}};
      rc_d = '0;
      fc_d = '0;
    end else if (cs_act) begin
      if (sclk_rise) begin
        rx_d = {rx_q[FRAME_W-2:0], mosi_s};
        if (rc_q != CNT_MAX) rc_d = rc_q + 1'b1;
      end
      if (sclk_fall) begin
        if (fc_q == HDR_FALLS) begin
          tx_d   = {low_byte_i, {LOW_PAD{1'b0}}};
          load_d = 1'b1;
        end else begin
          tx_d = {tx_q[FRAME_W-2:0], 1'b0};
        end
        if (fc_q != CNT_MAX) fc_d = fc_q + 1'b1;
      end
    end
    if (cs_rise) begin
      commit_d = 1'b1;
      ok_d     = (rc_q == FRAME_CNT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q     <= '0;
      tx_q     <= '0;
      rc_q     <= '0;
      fc_q     <= '0;
      load_q   <= 1'b0;
      commit_q <= 1'b0;
      ok_q     <= 1'b0;
    end else begin
      rx_q     <= rx_d;
      tx_q     <= tx_d;
      rc_q     <= rc_d;
      fc_q     <= fc_d;
      load_q   <= load_d;
      commit_q <= commit_d;
      ok_q     <= ok_d;
    end
  end

  assign miso_o      = cs_act & tx_q[FRAME_W-1];
  assign hdr_cmd_o   = cmd_e'(rx_q[DATA_W-1 -: CMD_BITS]);
  assign hdr_addr_o  = rx_q[DATA_W-1-CMD_BITS -: ADDR_W];
  assign low_load_o  = load_q;
  assign commit_o    = commit_q;
  assign commit_ok_o = ok_q;
  assign word_o      = rx_q;

  // R1: a frame is only ever committed once chip select has been released
  p_commit_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> cs_sh[SYNC-1]);

  // R1: an accepted frame never coexists with a failed one
  p_ok_in_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |-> commit_q);

  // R5: the second byte is loaded only after the header bits have arrived
  p_hdr_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> (rc_q >= CNT_W'(DATA_W)));

endmodule

// File: rtl/spi_challenge.sv
module spi_challenge #(
  parameter int              DATA_W     = 8,
  parameter logic [DATA_W-1:0] LFSR_TAPS  = 8'hB8,
  parameter logic [DATA_W-1:0] LFSR_SEED  = 8'h01,
  parameter logic [DATA_W-1:0] CODE_RESET = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_hit_i,
  input  logic              wr_hit_i,
  input  logic              wr_pn_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] code_o,
  output logic [DATA_W-1:0] mode_o
);

  logic [DATA_W-1:0] lfsr_q, lfsr_d, code_q, code_d, arm_q, arm_d, mode_q, mode_d;
  logic              armv_q, armv_d;

  always_comb begin
    lfsr_d = {lfsr_q[DATA_W-2:0], ^(lfsr_q & LFSR_TAPS)};
    code_d = code_q;
    arm_d  = arm_q;
    armv_d = armv_q;
    mode_d = mode_q;
    if (rd_hit_i) begin
      arm_d  = code_q;
      armv_d = 1'b1;
      code_d = lfsr_q;
    end else if (wr_hit_i) begin
      armv_d = 1'b0;
      if (armv_q && wr_pn_i && (wr_data_i == ~arm_q)) mode_d = wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= LFSR_SEED;
      code_q <= CODE_RESET;
      arm_q  <= '0;
      armv_q <= 1'b0;
      mode_q <= '0;
    end else begin
      lfsr_q <= lfsr_d;
      code_q <= code_d;
      arm_q  <= arm_d;
      armv_q <= armv_d;
      mode_q <= mode_d;
    end
  end

  assign code_o = code_q;
  assign mode_o = mode_q;

  // R11: the guarded register moves only on an armed write to its address
  p_mode_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> ($past(armv_q) && $past(wr_hit_i)));

  // R11: a write to the guarded address always consumes the arming
  p_disarm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit_i |=> !armv_q);

  // R10: the LFSR never locks up in the all-zero state
  p_lfsr_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_cmd_pkg::*;
#(
  parameter int FRAME_W     = FRAME_BITS,
  parameter int DATA_W      = BYTE_BITS,
  parameter int ADDR_W      = ADDR_BITS,
  parameter int NUM_INIT    = 5,
  parameter int NUM_SCRATCH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  cmd_e                       hdr_cmd_i,
  input  logic [ADDR_W-1:0]          hdr_addr_i,
  input  logic                       low_load_i,
  input  logic                       commit_i,
  input  logic                       commit_ok_i,
  input  logic [FRAME_W-1:0]         word_i,
  input  logic [DATA_W-1:0]          ext_status_i,
  input  logic [DATA_W-3:0]          evt_i,
  input  logic [DATA_W-1:0]          code_i,
  output logic [DATA_W-1:0]          low_byte_o,
  output logic [NUM_INIT*DATA_W-1:0] init_flat_o,
  output logic                       rd_hit_o,
  output logic                       wr_hit_o
);

  localparam int NUM_STORE = NUM_INIT + NUM_SCRATCH;
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NUM_STORE);
  localparam int FRM_BIT = DATA_W - 1;
  localparam int PAR_BIT = DATA_W - 2;
  localparam logic [FRAME_W-1:0] PN_MASK = FRAME_W'(1) << DATA_W;

  logic [DATA_W-1:0] store_q [NUM_STORE];
  logic [DATA_W-1:0] flag_q, flag_d, rep_q, rep_d, flag_set, flag_clr, rd_val;
  cmd_e              c_cmd;
  logic [ADDR_W-1:0] c_addr;
  logic              c_pn, par_en, par_bad, is_wr, wr_go;

  assign c_cmd   = cmd_e'(word_i[FRAME_W-1 -: CMD_BITS]);
  assign c_addr  = word_i[FRAME_W-1-CMD_BITS -: ADDR_W];
  assign c_pn    = word_i[DATA_W];
  assign par_en  = store_q[0][0];
  assign par_bad = par_en & (c_pn != ^(word_i & ~PN_MASK));
  assign is_wr   = commit_i & commit_ok_i & (c_cmd == CMD_WRITE);
  assign wr_go   = is_wr & ~par_bad & (c_addr < MODE_ADDR);
  assign wr_hit_o = is_wr & (c_addr == MODE_ADDR);
  assign rd_hit_o = commit_i & commit_ok_i & (c_cmd == CMD_RDBK) & (c_addr == MODE_ADDR);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_STORE; gi++) begin : g_store
      logic              en;
      logic [DATA_W-1:0] nxt;
      assign en  = wr_go & (c_addr == ADDR_W'(gi));
      assign nxt = en ? word_i[DATA_W-1:0] : store_q[gi];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) store_q[gi] <= '0;
        else        store_q[gi] <= nxt;
      end
      // R3 R6: a stored byte holds unless a write commits to it
      p_store_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_go |=> $stable(store_q[gi]));
    end
    for (gi = 0; gi < NUM_INIT; gi++) begin : g_init_out
      assign init_flat_o[gi*DATA_W +: DATA_W] = store_q[gi];
    end
  endgenerate

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_STORE; i++) begin
      if (hdr_addr_i == ADDR_W'(i)) rd_val = store_q[i];
    end
    if (hdr_addr_i == MODE_ADDR) rd_val = code_i;
    case (hdr_cmd_i)
      CMD_RDBK:  low_byte_o = rd_val;
      CMD_FLAGS: low_byte_o = flag_q;
      default:   low_byte_o = ext_status_i;
    endcase
  end

  always_comb begin
    flag_set          = {2'b00, evt_i};
    flag_set[FRM_BIT] = commit_i & ~commit_ok_i;
    flag_set[PAR_BIT] = is_wr & par_bad & (c_addr != MODE_ADDR);
    flag_clr = (commit_i & commit_ok_i & (c_cmd == CMD_FLAGS)) ? rep_q : '0;
    flag_d   = (flag_q & ~flag_clr) | flag_set;
    rep_d    = (low_load_i && hdr_cmd_i == CMD_FLAGS) ? flag_q : rep_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      rep_q  <= '0;
    end else begin
      flag_q <= flag_d;
      rep_q  <= rep_d;
    end
  end

  // R7: the framing flag is raised only by a discarded frame
  p_frame_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[FRM_BIT]) |-> $past(commit_i && !commit_ok_i));

  // R8: the parity flag is raised only by a committed write
  p_parity_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[PAR_BIT]) |-> $past(commit_i && commit_ok_i));

  // R9: flags drop only when a flag-read frame completes
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[FRM_BIT]) |-> $past(commit_i && commit_ok_i));

endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int FRAME_W     = FRAME_BITS,
  parameter int DATA_W      = BYTE_BITS,
  parameter int ADDR_W      = ADDR_BITS,
  parameter int NUM_INIT    = 5,
  parameter int NUM_SCRATCH = 4,
  parameter int SYNC        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic [DATA_W-1:0] fixed_status,
  input  logic [DATA_W-1:0] ext_status,
  input  logic [DATA_W-3:0] evt,
  output logic              miso,
  output logic [DATA_W-1:0] cfg_misc,
  output logic [DATA_W-1:0] cfg_linio,
  output logic [DATA_W-1:0] cfg_supply,
  output logic [DATA_W-1:0] cfg_wdog,
  output logic [DATA_W-1:0] cfg_amux,
  output logic [DATA_W-1:0] mode_sel
);

  logic [1:0]                rst_sh;
  logic                      rst_n_s;
  cmd_e                      hdr_cmd;
  logic [ADDR_W-1:0]         hdr_addr;
  logic                      low_load, commit, commit_ok, rd_hit, wr_hit;
  logic [FRAME_W-1:0]        word;
  logic [DATA_W-1:0]         low_byte, code;
  logic [NUM_INIT*DATA_W-1:0] init_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_n_s = rst_sh[1];

  spi_frame_port #(
    .FRAME_W(FRAME_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC(SYNC)
  ) u_port (
    .clk(clk), .rst_n(rst_n_s), .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi),
    .fixed_status_i(fixed_status), .low_byte_i(low_byte), .miso_o(miso),
    .hdr_cmd_o(hdr_cmd), .hdr_addr_o(hdr_addr), .low_load_o(low_load),
    .commit_o(commit), .commit_ok_o(commit_ok), .word_o(word)
  );

  spi_reg_bank #(
    .FRAME_W(FRAME_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .NUM_INIT(NUM_INIT), .NUM_SCRATCH(NUM_SCRATCH)
  ) u_bank (
    .clk(clk), .rst_n(rst_n_s), .hdr_cmd_i(hdr_cmd), .hdr_addr_i(hdr_addr),
    .low_load_i(low_load), .commit_i(commit), .commit_ok_i(commit_ok),
    .word_i(word), .ext_status_i(ext_status), .evt_i(evt), .code_i(code),
    .low_byte_o(low_byte), .init_flat_o(init_flat),
    .rd_hit_o(rd_hit), .wr_hit_o(wr_hit)
  );

  spi_challenge #(.DATA_W(DATA_W)) u_chal (
    .clk(clk), .rst_n(rst_n_s), .rd_hit_i(rd_hit), .wr_hit_i(wr_hit),
    .wr_pn_i(word[DATA_W]), .wr_data_i(word[DATA_W-1:0]),
    .code_o(code), .mode_o(mode_sel)
  );

  assign cfg_misc   = init_flat[0*DATA_W +: DATA_W];
  assign cfg_linio  = init_flat[1*DATA_W +: DATA_W];
  assign cfg_supply = init_flat[2*DATA_W +: DATA_W];
  assign cfg_wdog   = init_flat[3*DATA_W +: DATA_W];
  assign cfg_amux   = init_flat[4*DATA_W +: DATA_W];

  // R2: MISO is quiet while chip select is high
  p_miso_idle_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(cs_n) && cs_n && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso);

endmodule

// File: tb/spi_cmd_slave_tb.sv
module spi_cmd_slave_tb;

  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [7:0] fixed_status = 8'h00, ext_status = 8'h00;
  logic [5:0] evt = 6'h00;
  logic miso;
  logic [7:0] cfg_misc, cfg_linio, cfg_supply, cfg_wdog, cfg_amux, mode_sel;

  int nvec = 0, nfail = 0;
  logic [7:0] st [9];
  logic [7:0] fl;
  logic [7:0] mode_exp;

  always #4 clk = ~clk;

  spi_cmd_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .fixed_status(fixed_status), .ext_status(ext_status), .evt(evt),
    .miso(miso), .cfg_misc(cfg_misc), .cfg_linio(cfg_linio),
    .cfg_supply(cfg_supply), .cfg_wdog(cfg_wdog), .cfg_amux(cfg_amux),
    .mode_sel(mode_sel)
  );

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic par16(input logic [15:0] w);
    return ^{w[15:9], w[7:0]};
  endfunction

  function automatic logic [15:0] mk(input logic [1:0] c, input logic [4:0] a,
                                     input logic pn, input logic [7:0] d);
    return {c, a, pn, d};
  endfunction

  task automatic xfer(input logic [15:0] w, input int nbits, output logic [15:0] r);
    r = '0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < 16) r[15-i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  // Full model-checked frame for addresses other than 9.
  task automatic run(input string req, input logic [15:0] w);
    logic [15:0] r;
    logic [7:0] exp_lo;
    logic [1:0] c = w[15:14];
    logic [4:0] a = w[13:9];
    fixed_status = 8'($urandom);
    ext_status   = 8'($urandom);
    if (c == 2'b00)      exp_lo = (a < 9) ? st[a] : 8'h00;
    else if (c == 2'b11) exp_lo = fl;
    else                 exp_lo = ext_status;
    xfer(w, 16, r);
    check({req, " R2 status"}, {32'h0, r[15:8]}, {32'h0, fixed_status});
    check({req, " low byte"}, {32'h0, r[7:0]}, {32'h0, exp_lo});
    if (c == 2'b11) fl = 8'h00;
    if (c == 2'b01 && a != 5'd9) begin
      if (st[0][0] && (w[8] != par16(w))) fl[6] = 1'b1;
      else if (a < 9) st[a] = w[7:0];
    end
    check({req, " R3 cfg"}, {cfg_misc, cfg_linio, cfg_supply, cfg_wdog, cfg_amux},
          {st[0], st[1], st[2], st[3], st[4]});
    check({req, " R11 mode"}, {32'h0, mode_sel}, {32'h0, mode_exp});
  endtask

  task automatic rd_code(output logic [7:0] code);
    logic [15:0] r;
    xfer(mk(2'b00, 5'd9, 1'b0, 8'h00), 16, r);
    code = r[7:0];
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin : stim
    logic [15:0] r;
    logic [7:0] code, d;
    logic [4:0] a;
    logic [1:0] c;
    void'($urandom(32'h5EED_2024));
    for (int i = 0; i < 9; i++) st[i] = 8'h00;
    fl = 8'h00;
    mode_exp = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    check("R3 reset cfg", {cfg_misc, cfg_linio, cfg_supply, cfg_wdog, cfg_amux}, 40'h0);
    check("R11 reset mode", {32'h0, mode_sel}, 40'h0);
    check("R2 idle miso", {39'h0, miso}, 40'h0);

    // R10: first challenge read after reset
    fixed_status = 8'hC3;
    xfer(mk(2'b00, 5'd9, 1'b0, 8'h00), 16, r);
    check("R10 reset code", {32'h0, r[7:0]}, {32'h0, 8'h5A});
    check("R2 fixed byte", {32'h0, r[15:8]}, {32'h0, 8'hC3});
    // R11: correct inverse with bit 8 set
    ext_status = 8'h96;
    xfer(mk(2'b01, 5'd9, 1'b1, 8'hA5), 16, r);
    check("R5 write low byte", {32'h0, r[7:0]}, {32'h0, 8'h96});
    mode_exp = 8'hA5;
    check("R11 accepted", {32'h0, mode_sel}, {32'h0, mode_exp});
    // R11: disarmed after use
    xfer(mk(2'b01, 5'd9, 1'b1, 8'h00), 16, r);
    check("R11 replay rejected", {32'h0, mode_sel}, {32'h0, mode_exp});
    // R11: bit 8 clear rejected
    rd_code(code);
    xfer(mk(2'b01, 5'd9, 1'b0, ~code), 16, r);
    check("R11 pn clear rejected", {32'h0, mode_sel}, {32'h0, mode_exp});
    // R11: wrong code rejected
    rd_code(code);
    xfer(mk(2'b01, 5'd9, 1'b1, ~code ^ 8'h01), 16, r);
    check("R11 wrong code rejected", {32'h0, mode_sel}, {32'h0, mode_exp});
    // R10 R11: fresh code works
    rd_code(code);
    xfer(mk(2'b01, 5'd9, 1'b1, ~code), 16, r);
    mode_exp = ~code;
    check("R10 fresh code accepted", {32'h0, mode_sel}, {32'h0, mode_exp});

    // Random traffic, parity off (R1 R3 R4 R5 R9)
    for (int n = 0; n < 180; n++) begin
      c = 2'($urandom);
      a = 5'($urandom_range(0, 12));
      if (a == 5'd9) a = 5'd8;
      d = 8'($urandom);
      if (a == 5'd0) d[0] = 1'b0;
      run("R1 random", mk(c, a, 1'($urandom), d));
    end

    // R6: reserved command leaves scratch untouched
    run("R6 write base", mk(2'b01, 5'd5, 1'b0, 8'h3C));
    run("R6 reserved", mk(2'b10, 5'd5, 1'b0, 8'hC3));
    run("R6 readback", mk(2'b00, 5'd5, 1'b0, 8'h00));

    // R4: out-of-range addresses
    run("R4 write high addr", mk(2'b01, 5'd20, 1'b0, 8'h77));
    run("R4 read high addr", mk(2'b00, 5'd20, 1'b0, 8'h00));

    // R7: short frame discarded, framing flag set
    xfer(mk(2'b01, 5'd6, 1'b0, 8'hEE), 15, r);
    fl[7] = 1'b1;
    run("R7 short frame no write", mk(2'b00, 5'd6, 1'b0, 8'h00));
    run("R9 flag read frame err", mk(2'b11, 5'd3, 1'b0, 8'h00));
    run("R9 flags cleared", mk(2'b11, 5'd0, 1'b0, 8'h00));
    // R7: long frame discarded
    xfer(mk(2'b01, 5'd6, 1'b0, 8'hEE), 17, r);
    fl[7] = 1'b1;
    run("R7 long frame no write", mk(2'b00, 5'd6, 1'b0, 8'h00));
    run("R7 long frame flag", mk(2'b11, 5'd1, 1'b0, 8'h00));

    // R9: event inputs are sticky
    @(negedge clk); evt = 6'h05;
    @(negedge clk); evt = 6'h00;
    fl[5:0] = fl[5:0] | 6'h05;
    run("R9 event flags", mk(2'b11, 5'd2, 1'b0, 8'h00));
    run("R9 event cleared", mk(2'b11, 5'd2, 1'b0, 8'h00));

    // R8: parity checking
    run("R8 enable parity", mk(2'b01, 5'd0, 1'b0, 8'h01));
    begin
      logic [15:0] w = mk(2'b01, 5'd7, 1'b0, 8'h5B);
      w[8] = ~par16(w);
      run("R8 bad parity dropped", w);
      run("R8 scratch kept", mk(2'b00, 5'd7, 1'b0, 8'h00));
      run("R8 parity flag", mk(2'b11, 5'd0, 1'b0, 8'h00));
      w[8] = par16(w);
      run("R8 good parity accepted", w);
      run("R8 scratch written", mk(2'b00, 5'd7, 1'b0, 8'h00));
    end
    // R11: parity exempt on the guarded register
    rd_code(code);
    xfer(mk(2'b01, 5'd9, 1'b1, ~code), 16, r);
    mode_exp = ~code;
    check("R11 parity exempt", {32'h0, mode_sel}, {32'h0, mode_exp});
    run("R8 no parity flag", mk(2'b11, 5'd0, 1'b0, 8'h00));

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule